// File: doc/BRIEF.md
# Register-File Eight-Bit Processing Unit

This block is the execution core of a small processor. Eight general registers, each eight bits wide, feed an arithmetic and logic unit through two combinational read ports, and the result returns over one write port to the register named by the write address. A four-bit status register tracks carry, zero, signed overflow and negative. An external sequencer presents an operation code and register addresses each cycle. While the enable input is high, the block carries out that operation on the next rising clock edge.

Besides arithmetic, logic and shift work, the unit moves bytes between a memory data bus and the registers. It sets, clears and tests single status flags. It also decides zero and carry conditional branches. On a taken branch it raises a strobe and presents a register's contents as the jump offset for a program counter outside the block. Fetch, instruction decode and the program counter itself belong to the surrounding design.

Top module: `rf_alu_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight registers and all four flags. `statusFlags` shows the flags as bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C.
- R2: Opcode 1 writes `memIn` into register `wrAddr` and leaves the flags alone. While opcode 2 is applied, `memWrite` is 1. `memOut` always shows register `rdA`, and opcode 2 changes no register and no flag.
- R3: Opcode 5 writes A+B and opcode 6 writes A+B+C, where A is register `rdA` and B is register `rdB`. C takes the carry out. V is set when A and B have the same sign and the result sign differs from it. Z and N follow the result.
- R4: Opcode 7 writes A−B. C becomes 1 exactly when no borrow occurs (A ≥ B unsigned). V is set when A and B differ in sign and the result sign differs from A. Z and N follow the result.
- R5: Opcode 8 writes A+1. C takes the carry out, V is set only for A = 0x7F, and Z and N follow the result.
- R6: Opcodes 9, 10, 11 and 12 write A AND B, A OR B, A XOR B and NOT A. Z and N follow the result, V is cleared and C is kept.
- R7: Opcode 3 shifts A left by one and opcode 4 shifts it right by one, both with a zero fill. C takes the bit shifted out, V is cleared, and Z and N follow the result.
- R8: Opcode 13 sets and opcode 14 clears the flag chosen by `flagSel` (0 = C, 1 = Z, 2 = V, 3 = N). The other flags and the registers stay as they are.
- R9: While opcode 15 is applied, `flagBit` shows the flag chosen by `flagSel`. No register or flag changes.
- R10: Opcode 16 raises `branchTaken` only when Z is 1, and opcode 17 only when C is 1. `branchTarget` shows register `rdA` when the branch is taken and 0 otherwise. Flags and registers do not change.
- R11: While `en` is 0, no register or flag changes, and `memWrite`, `flagBit` and `branchTaken` stay 0.
- R12: Opcode 0 and opcodes 18 to 31 change no register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Execute the presented operation this cycle |
| opCode | input | 5 | Operation code |
| wrAddr | input | 3 | Destination register |
| rdA | input | 3 | First operand register |
| rdB | input | 3 | Second operand register |
| flagSel | input | 2 | Flag index for set, clear and test |
| memIn | input | 8 | Load data from memory |
| memOut | output | 8 | Register `rdA`, the store data |
| memWrite | output | 1 | Store strobe |
| flagBit | output | 1 | Tested flag value |
| branchTaken | output | 1 | Branch condition met |
| branchTarget | output | 8 | Branch offset for the external program counter |
| statusFlags | output | 4 | {N, V, Z, C} |

## Verification
The flags appear directly on `statusFlags`, so a wrong flag update shows on the first sample after the edge that caused it. A wrong register value stays hidden until something reads that register. The bench therefore reads the destination register through `memOut` right after every operation, which exposes a bad write one cycle after it happens and before later operations can mask it. The branch and test outputs are combinational from the stored flags, so they also expose flag corruption in the same cycle the operation is presented.

// File: rtl/dpu_pkg.sv
package dpu_pkg;

  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,
    OP_LOAD  = 5'd1,
    OP_STORE = 5'd2,
    OP_SHL   = 5'd3,
    OP_SHR   = 5'd4,
    OP_ADD   = 5'd5,
    OP_ADC   = 5'd6,
    OP_SUB   = 5'd7,
    OP_INC   = 5'd8,
    OP_AND   = 5'd9,
    OP_OR    = 5'd10,
    OP_XOR   = 5'd11,
    OP_NOT   = 5'd12,
    OP_SETF  = 5'd13,
    OP_CLRF  = 5'd14,
    OP_TSTF  = 5'd15,
    OP_BZ    = 5'd16,
    OP_BC    = 5'd17
  } opcode_e;

  typedef enum logic [3:0] {
    ALU_SHL, ALU_SHR, ALU_ADD, ALU_ADC, ALU_SUB,
    ALU_INC, ALU_AND, ALU_OR, ALU_XOR, ALU_NOT
  } alusel_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_V = 2;
  localparam int FLAG_N = 3;
  localparam int NFLAGS = 4;

  typedef struct packed {
    logic    regWr;
    logic    selMem;
    alusel_e aluSel;
    logic    updC;
    logic    updZN;
    logic    updV;
    logic    flagSet;
    logic    flagClr;
    logic    flagTest;
    logic    brZero;
    logic    brCarry;
    logic    memWr;
  } ctl_t;

endpackage

// File: rtl/dpu_ctrl.sv
module dpu_ctrl
  import dpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [4:0] opCode,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '0;
    if (en) begin
      case (opCode)
        OP_LOAD:  begin ctl.regWr = 1'b1; ctl.selMem = 1'b1; end
        OP_STORE: ctl.memWr = 1'b1;
        OP_SHL:   begin ctl.regWr = 1'b1; ctl.aluSel = ALU_SHL; ctl.updC = 1'b1; ctl.updZN = 1'b1; ctl.updV = 1'b1; end
        OP_SHR:   begin ctl.regWr = 1'b1; ctl.aluSel = ALU_SHR; ctl.updC = 1'b1; ctl.updZN = 1'b1; ctl.updV = 1'b1; end
        OP_ADD:   begin ctl.regWr = 1'b1; ctl.aluSel = ALU_ADD; ctl.updC = 1'b1; ctl.updZN = 1'b1; ctl.updV = 1'b1; end
        OP_ADC:   begin ctl.regWr = 1'b1; ctl.aluSel = ALU_ADC; ctl.updC = 1'b1; ctl.updZN = 1'b1; ctl.updV = 1'b1; end
        OP_SUB:   begin ctl.regWr = 1'b1; ctl.aluSel = ALU_SUB; ctl.updC = 1'b1; ctl.updZN = 1'b1; ctl.updV = 1'b1; end
        OP_INC:   begin ctl.regWr = 1'b1; ctl.aluSel = ALU_INC; ctl.updC = 1'b1; ctl.updZN = 1'b1; ctl.updV = 1'b1; end
        OP_AND:   begin ctl.regWr = 1'b1; ctl.aluSel = ALU_AND; ctl.updZN = 1'b1; ctl.updV = 1'b1; end
        OP_OR:    begin ctl.regWr = 1'b1; ctl.aluSel = ALU_OR;  ctl.updZN = 1'b1; ctl.updV = 1'b1; end
        OP_XOR:   begin ctl.regWr = 1'b1; ctl.aluSel = ALU_XOR; ctl.updZN = 1'b1; ctl.updV = 1'b1; end
        OP_NOT:   begin ctl.regWr = 1'b1; ctl.aluSel = ALU_NOT; ctl.updZN = 1'b1; ctl.updV = 1'b1; end
        OP_SETF:  ctl.flagSet  = 1'b1;
        OP_CLRF:  ctl.flagClr  = 1'b1;
        OP_TSTF:  ctl.flagTest = 1'b1;
        OP_BZ:    ctl.brZero   = 1'b1;
        OP_BC:    ctl.brCarry  = 1'b1;
        default:  ctl = '0;
      endcase
    end
  end

  // R8: at most one flag-manipulation strobe per cycle
  p_flagop_single_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.flagSet, ctl.flagClr, ctl.flagTest}));

  // R2: a store never writes the register file
  p_store_no_regwr_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.memWr |-> !ctl.regWr);

endmodule

// File: rtl/dpu_alu.sv
module dpu_alu
  import dpu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alusel_e          sel,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cOut,
  output logic             vOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] ext;

  always_comb begin
    ext  = '0;
    res  = '0;
    cOut = 1'b0;
    vOut = 1'b0;
    case (sel)
      ALU_SHL: begin res = {a[MSB-1:0], 1'b0}; cOut = a[MSB]; end
      ALU_SHR: begin res = {1'b0, a[MSB:1]};   cOut = a[0];   end
      ALU_ADD: begin
        ext  = {1'b0, a} + {1'b0, b};
        res  = ext[MSB:0];
        cOut = ext[WIDTH];
        vOut = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
      end
      ALU_ADC: begin
        ext  = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        res  = ext[MSB:0];
        cOut = ext[WIDTH];
        vOut = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
      end
      ALU_SUB: begin
        ext  = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
        res  = ext[MSB:0];
        cOut = ext[WIDTH];
        vOut = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
      end
      ALU_INC: begin
        ext  = {1'b0, a} + {{WIDTH{1'b0}}, 1'b1};
        res  = ext[MSB:0];
        cOut = ext[WIDTH];
        vOut = !a[MSB] && res[MSB];
      end
      ALU_AND: res = a & b;
      ALU_OR:  res = a | b;
      ALU_XOR: res = a ^ b;
      ALU_NOT: res = ~a;
      default: res = '0;
    endcase
  end

  // R4: subtract carry is the unsigned not-borrow
  always_comb begin
    if (sel == ALU_SUB)
      p_sub_noborrow_r4: assert (cOut == (a >= b));
  end

endmodule

// File: rtl/dpu_data.sv
module dpu_data
  import dpu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NREGS = 8,
  localparam int AW   = $clog2(NREGS),
  localparam int FW   = $clog2(NFLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdA,
  input  logic [AW-1:0]     rdB,
  input  logic [FW-1:0]     flagSel,
  input  logic [WIDTH-1:0]  memIn,
  output logic [WIDTH-1:0]  opA,
  output logic [NFLAGS-1:0] flagsQ,
  output logic              flagBit,
  output logic              branchTaken,
  output logic [WIDTH-1:0]  branchTarget
);

  logic [WIDTH-1:0]  regs [NREGS];
  logic [WIDTH-1:0]  opB;
  logic [WIDTH-1:0]  aluRes;
  logic [WIDTH-1:0]  busData;
  logic              aluC;
  logic              aluV;
  logic [NREGS-1:0]  wrHit;
  logic [NFLAGS-1:0] flagsNext;

  assign opA = regs[rdA];
  assign opB = regs[rdB];

  dpu_alu #(.WIDTH(WIDTH)) u_alu (
    .sel  (ctl.aluSel),
    .a    (opA),
    .b    (opB),
    .cin  (flagsQ[FLAG_C]),
    .res  (aluRes),
    .cOut (aluC),
    .vOut (aluV)
  );

  // shared write-back bus: memory data or ALU result
  assign busData = ctl.selMem ? memIn : aluRes;

  for (genvar g = 0; g < NREGS; g++) begin : g_wrdec
    assign wrHit[g] = ctl.regWr && (wrAddr == AW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREGS; i++) begin
      if (rst)           regs[i] <= '0;
      else if (wrHit[i]) regs[i] <= busData;
    end
  end

  always_comb begin
    flagsNext = flagsQ;
    if (ctl.updC)  flagsNext[FLAG_C] = aluC;
    if (ctl.updV)  flagsNext[FLAG_V] = aluV;
    if (ctl.updZN) begin
      flagsNext[FLAG_Z] = (aluRes == '0);
      flagsNext[FLAG_N] = aluRes[WIDTH-1];
    end
    if (ctl.flagSet) flagsNext[flagSel] = 1'b1;
    if (ctl.flagClr) flagsNext[flagSel] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) flagsQ <= '0;
    else     flagsQ <= flagsNext;
  end

  assign flagBit      = ctl.flagTest && flagsQ[flagSel];
  assign branchTaken  = (ctl.brZero && flagsQ[FLAG_Z]) || (ctl.brCarry && flagsQ[FLAG_C]);
  assign branchTarget = branchTaken ? opA : '0;

  // R9: a flag test leaves the status register unchanged
  p_test_keeps_flags_r9: assert property (@(posedge clk) disable iff (rst)
    ctl.flagTest |=> $stable(flagsQ));

endmodule

// File: rtl/rf_alu_unit.sv
module rf_alu_unit
  import dpu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NREGS = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [4:0]       opCode,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdA,
  input  logic [AW-1:0]    rdB,
  input  logic [1:0]       flagSel,
  input  logic [WIDTH-1:0] memIn,
  output logic [WIDTH-1:0] memOut,
  output logic             memWrite,
  output logic             flagBit,
  output logic             branchTaken,
  output logic [WIDTH-1:0] branchTarget,
  output logic [3:0]       statusFlags
);

  ctl_t ctl;

  dpu_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .opCode (opCode),
    .ctl    (ctl)
  );

  dpu_data #(.WIDTH(WIDTH), .NREGS(NREGS)) u_data (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .wrAddr       (wrAddr),
    .rdA          (rdA),
    .rdB          (rdB),
    .flagSel      (flagSel),
    .memIn        (memIn),
    .opA          (memOut),
    .flagsQ       (statusFlags),
    .flagBit      (flagBit),
    .branchTaken  (branchTaken),
    .branchTarget (branchTarget)
  );

  assign memWrite = ctl.memWr;

  // R1: reset clears the status register
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (statusFlags == 4'b0000));

  // R11: idle cycles hold the flags
  p_idle_flags_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(statusFlags));

  // R10: a taken branch needs Z or C set
  p_branch_cond_r10: assert property (@(posedge clk) disable iff (rst)
    branchTaken |-> (statusFlags[1] || statusFlags[0]));

  // R2: store strobe only while enabled
  p_store_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> en);

endmodule

// File: tb/sim_rf_alu_unit.sv
module sim_rf_alu_unit;
  import dpu_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [4:0] opCode = 5'd0;
  logic [2:0] wrAddr = '0, rdA = '0, rdB = '0;
  logic [1:0] flagSel = '0;
  logic [7:0] memIn = '0;
  logic [7:0] memOut, branchTarget;
  logic       memWrite, flagBit, branchTaken;
  logic [3:0] statusFlags;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rf_alu_unit u0 (
    .clk(clk), .rst(rst), .en(en), .opCode(opCode), .wrAddr(wrAddr),
    .rdA(rdA), .rdB(rdB), .flagSel(flagSel), .memIn(memIn),
    .memOut(memOut), .memWrite(memWrite), .flagBit(flagBit),
    .branchTaken(branchTaken), .branchTarget(branchTarget),
    .statusFlags(statusFlags)
  );

  // {op, A, B, C before, result, flags {N,V,Z,C}}; V, Z, N preset to 1
  localparam int NV = 16;
  localparam logic [33:0] VEC [NV] = '{
    {OP_ADD, 8'h7F, 8'h01, 1'b0, 8'h80, 4'b1100},
    {OP_ADD, 8'hFF, 8'h01, 1'b0, 8'h00, 4'b0011},
    {OP_ADC, 8'h10, 8'h20, 1'b1, 8'h31, 4'b0000},
    {OP_ADC, 8'hFF, 8'h00, 1'b1, 8'h00, 4'b0011},
    {OP_SUB, 8'h05, 8'h03, 1'b0, 8'h02, 4'b0001},
    {OP_SUB, 8'h03, 8'h05, 1'b1, 8'hFE, 4'b1000},
    {OP_SUB, 8'h80, 8'h01, 1'b0, 8'h7F, 4'b0101},
    {OP_INC, 8'h7F, 8'h00, 1'b0, 8'h80, 4'b1100},
    {OP_INC, 8'hFF, 8'h00, 1'b0, 8'h00, 4'b0011},
    {OP_AND, 8'hF0, 8'h3C, 1'b1, 8'h30, 4'b0001},
    {OP_OR,  8'h00, 8'h00, 1'b0, 8'h00, 4'b0010},
    {OP_XOR, 8'hAA, 8'h55, 1'b0, 8'hFF, 4'b1000},
    {OP_NOT, 8'h0F, 8'h00, 1'b1, 8'hF0, 4'b1001},
    {OP_SHL, 8'h81, 8'h00, 1'b0, 8'h02, 4'b0001},
    {OP_SHR, 8'h01, 8'h00, 1'b0, 8'h00, 4'b0011},
    {OP_SHR, 8'h80, 8'h00, 1'b1, 8'h40, 4'b0000}
  };

  function automatic string reqOf(input logic [4:0] op);
    case (op)
      OP_ADD, OP_ADC: return "R3";
      OP_SUB: return "R4";
      OP_INC: return "R5";
      OP_SHL, OP_SHR: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [2:0] wa, input logic [2:0] ra,
                       input logic [2:0] rb, input logic [1:0] fs, input logic [7:0] mi);
    @(negedge clk);
    en = 1'b1; opCode = op; wrAddr = wa; rdA = ra; rdB = rb; flagSel = fs; memIn = mi;
    @(posedge clk);
    #1;
    opCode = OP_NOP;
  endtask

  task automatic peek(input logic [2:0] ra, output logic [7:0] v);
    rdA = ra;
    #1;
    v = memOut;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++;
    errs++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [4:0] op;
    logic [7:0] a, b, res;
    logic       cin;
    logic [3:0] fl;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1", "flags after reset", statusFlags, 4'b0000);
    for (int r = 0; r < 8; r++) begin
      peek(3'(r), v);
      chk("R1", "register after reset", v, 8'h00);
    end

    // R3..R7: vector table
    for (int i = 0; i < NV; i++) begin
      {op, a, b, cin, res, fl} = VEC[i];
      issue(OP_LOAD, 3'd1, 3'd0, 3'd0, 2'd0, a);
      issue(OP_LOAD, 3'd2, 3'd0, 3'd0, 2'd0, b);
      issue(OP_SETF, 3'd0, 3'd0, 3'd0, 2'd1, 8'h00);
      issue(OP_SETF, 3'd0, 3'd0, 3'd0, 2'd2, 8'h00);
      issue(OP_SETF, 3'd0, 3'd0, 3'd0, 2'd3, 8'h00);
      issue(cin ? OP_SETF : OP_CLRF, 3'd0, 3'd0, 3'd0, 2'd0, 8'h00);
      issue(op, 3'd3, 3'd1, 3'd2, 2'd0, 8'h00);
      chk(reqOf(op), "flags", statusFlags, fl);
      peek(3'd3, v);
      chk(reqOf(op), "result", v, res);
    end

    // R1: reset after use
    issue(OP_LOAD, 3'd5, 3'd0, 3'd0, 2'd0, 8'h5A);
    issue(OP_SETF, 3'd0, 3'd0, 3'd0, 2'd1, 8'h00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", "flags after second reset", statusFlags, 4'b0000);
    peek(3'd5, v);
    chk("R1", "r5 after second reset", v, 8'h00);

    // R2: load leaves flags, store strobe
    issue(OP_SETF, 3'd0, 3'd0, 3'd0, 2'd3, 8'h00);
    issue(OP_SETF, 3'd0, 3'd0, 3'd0, 2'd0, 8'h00);
    issue(OP_LOAD, 3'd4, 3'd0, 3'd0, 2'd0, 8'h00);
    chk("R2", "flags after load of zero", statusFlags, 4'b1001);
    peek(3'd4, v);
    chk("R2", "loaded r4", v, 8'h00);
    issue(OP_LOAD, 3'd6, 3'd0, 3'd0, 2'd0, 8'h9C);
    @(negedge clk);
    opCode = OP_STORE; rdA = 3'd6; wrAddr = 3'd6; memIn = 8'h11;
    #1;
    chk("R2", "memWrite during store", memWrite, 1'b1);
    chk("R2", "store data", memOut, 8'h9C);
    @(posedge clk); #1; opCode = OP_NOP;
    #1;
    chk("R2", "memWrite after store", memWrite, 1'b0);
    chk("R2", "flags after store", statusFlags, 4'b1001);
    peek(3'd6, v);
    chk("R2", "r6 after store", v, 8'h9C);

    // R8: set and clear single flags
    issue(OP_SETF, 3'd0, 3'd0, 3'd0, 2'd1, 8'h00);
    chk("R8", "set Z", statusFlags, 4'b1011);
    issue(OP_CLRF, 3'd0, 3'd0, 3'd0, 2'd3, 8'h00);
    chk("R8", "clear N", statusFlags, 4'b0011);
    issue(OP_SETF, 3'd0, 3'd0, 3'd0, 2'd2, 8'h00);
    chk("R8", "set V", statusFlags, 4'b0111);
    issue(OP_CLRF, 3'd0, 3'd0, 3'd0, 2'd0, 8'h00);
    chk("R8", "clear C", statusFlags, 4'b0110);

    // R9: flag test
    @(negedge clk);
    opCode = OP_TSTF; flagSel = 2'd1; wrAddr = 3'd6;
    #1;
    chk("R9", "test Z", flagBit, 1'b1);
    flagSel = 2'd0;
    #1;
    chk("R9", "test C", flagBit, 1'b0);
    @(posedge clk); #1; opCode = OP_NOP;
    chk("R9", "flags after test", statusFlags, 4'b0110);
    peek(3'd6, v);
    chk("R9", "r6 after test", v, 8'h9C);

    // R10: branches, Z=1 C=0
    issue(OP_LOAD, 3'd7, 3'd0, 3'd0, 2'd0, 8'h24);
    @(negedge clk);
    opCode = OP_BZ; rdA = 3'd7;
    #1;
    chk("R10", "BZ taken", branchTaken, 1'b1);
    chk("R10", "BZ target", branchTarget, 8'h24);
    opCode = OP_BC;
    #1;
    chk("R10", "BC not taken", branchTaken, 1'b0);
    chk("R10", "BC target idle", branchTarget, 8'h00);
    @(posedge clk); #1; opCode = OP_NOP;
    chk("R10", "flags after branch", statusFlags, 4'b0110);
    issue(OP_CLRF, 3'd0, 3'd0, 3'd0, 2'd1, 8'h00);
    issue(OP_SETF, 3'd0, 3'd0, 3'd0, 2'd0, 8'h00);
    @(negedge clk);
    opCode = OP_BZ; rdA = 3'd7;
    #1;
    chk("R10", "BZ not taken", branchTaken, 1'b0);
    opCode = OP_BC;
    #1;
    chk("R10", "BC taken", branchTaken, 1'b1);
    chk("R10", "BC target", branchTarget, 8'h24);
    @(posedge clk); #1; opCode = OP_NOP;

    // R11: enable low
    @(negedge clk);
    en = 1'b0; opCode = OP_ADD; wrAddr = 3'd7; rdA = 3'd6; rdB = 3'd6;
    @(posedge clk); #1;
    opCode = OP_STORE;
    #1;
    chk("R11", "no store strobe", memWrite, 1'b0);
    opCode = OP_BC;
    #1;
    chk("R11", "no branch", branchTaken, 1'b0);
    opCode = OP_SETF; flagSel = 2'd3;
    @(posedge clk); #1;
    chk("R11", "flags while idle", statusFlags, 4'b0101);
    peek(3'd7, v);
    chk("R11", "r7 while idle", v, 8'h24);

    // R12: undefined codes and NOP
    issue(5'd20, 3'd7, 3'd6, 3'd6, 2'd3, 8'hEE);
    issue(5'd31, 3'd7, 3'd6, 3'd6, 2'd3, 8'hEE);
    issue(OP_NOP, 3'd7, 3'd6, 3'd6, 2'd3, 8'hEE);
    chk("R12", "flags after undefined", statusFlags, 4'b0101);
    peek(3'd7, v);
    chk("R12", "r7 after undefined", v, 8'h24);

    finish_run();
  end

endmodule